// File: doc/BRIEF.md
# CAN Bit Timing Sequencer and Bus Sampler

This block divides each bit of a CAN-style serial bus into quanta and walks through them. It is driven by a time-quantum tick that a prescaler outside the block supplies. A bit starts with a one-quantum synchronisation segment. A first phase segment follows, then a second phase segment, and the length of each phase comes from an 8-bit timing word. At the end of the first phase the block samples the receive line and emits a sample strobe with the decoded bit. At the start of each bit it emits a transmit strobe, so that the transmitter can drive the next bit.

Two sampling modes exist. In single mode the bus value at the sample point is the bit. In triple mode the bit is the majority of the sample-point value and the values at the two quantum boundaries just before it. To keep those two early samples inside the first phase, a first-phase field below 2 is raised to 2 in triple mode, and a configuration error is flagged. When the bus is marked idle, a falling (recessive-to-dominant) edge restarts the sequence at the synchronisation segment.

The sequencer has three states: SYNC, PHASE1 and PHASE2. On a tick, SYNC goes to PHASE1. On a tick, PHASE1 goes to PHASE2 once its quantum count has reached the first-phase field; this transition is the sample point. On a tick, PHASE2 goes to SYNC once its count has reached the second-phase field; this transition is the transmit point. A hard-sync edge forces SYNC from any state, and it takes priority over a tick in the same cycle.

Top module: `can_bit_timer`

## Requirements
- R1: `timing_cfg` bit 7 selects triple sampling (1) or single sampling (0). Bits 6:4 are the second-phase field P2 and bits 3:0 are the first-phase field P1. After reset `sample_stb`, `tx_stb` and `cfg_err` are 0, `sample_bit` is 1, and the sequencer is in SYNC. With the all-zero word a bit lasts 3 quanta.
- R2: A bit lasts 1 + (P1e+1) + (P2+1) ticks, where P1e is the effective first-phase field. `tx_stb` pulses once per bit, after the tick that ends the last PHASE2 quantum, which is the start of the next bit. The first tick after reset or hard sync ends SYNC.
- R3: `sample_stb` pulses after the tick that ends the last PHASE1 quantum, which is the (P1e+2)-th tick of the bit counted from the tick that ends SYNC as tick 1.
- R4: In single mode `sample_bit` equals `bus_rx` as it was in the sample-point tick cycle.
- R5: In triple mode `sample_bit` is the majority of `bus_rx` in the sample-point tick cycle and in the two tick cycles before it.
- R6: In triple mode with P1 < 2, P1e is 2 and `cfg_err` is 1. Otherwise P1e is P1 and `cfg_err` is 0.
- R7: With `bus_idle` at 1, a 1-to-0 change of `bus_rx` between two consecutive clock cycles puts the sequencer back in SYNC. No strobe results from that change.
- R8: With `bus_idle` at 0, a falling edge of `bus_rx` has no effect on the timing of the strobes.
- R9: Each strobe is high for exactly one clock cycle, the cycle after a tick cycle. The two strobes are never high together. `sample_bit` changes only together with a `sample_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_tick | input | 1 | One-cycle pulse marking the end of a time quantum |
| timing_cfg | input | 8 | Sampling mode [7], second-phase field [6:4], first-phase field [3:0] |
| bus_rx | input | 1 | Receive line, 1 is recessive |
| bus_idle | input | 1 | High while no frame is in progress; enables hard sync |
| sample_stb | output | 1 | Pulse at the sample point |
| sample_bit | output | 1 | Decoded bit value, held between sample strobes |
| tx_stb | output | 1 | Pulse at the transmit point (start of bit) |
| cfg_err | output | 1 | Triple-sampling first-phase minimum was violated and clamped |

## Verification
On every cycle the assertions check four things: that strobes follow a tick and never coincide, that the sequencer holds its state between ticks, that a hard sync lands in SYNC and is only taken while idle, and that the sampled bit changes only with its strobe. The bench scenarios are needed for the rest. Only they show the exact bit length and sample position for given fields, the majority result against glitch patterns, the clamped position together with its error flag, and the realignment after an idle-bus edge compared with an ignored edge during traffic.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    typedef enum logic [1:0] {
        ST_SYNC   = 2'd0,
        ST_PHASE1 = 2'd1,
        ST_PHASE2 = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_cfg_decode.sv
module cbt_cfg_decode #(
    parameter int P1_W    = 4,
    parameter int P2_W    = 3,
    parameter int MIN_P1  = 2,
    localparam int CFG_W  = 1 + P1_W + P2_W
) (
    input  logic [CFG_W-1:0] cfg,
    output logic             triple,
    output logic [P1_W-1:0]  p1_eff,
    output logic [P2_W-1:0]  p2,
    output logic             too_short
);
    localparam logic [P1_W-1:0] MIN_V = MIN_P1[P1_W-1:0];

    logic [P1_W-1:0] p1_raw;

    always_comb begin
        p1_raw    = cfg[P1_W-1:0];
        p2        = cfg[P1_W +: P2_W];
        triple    = cfg[CFG_W-1];
        too_short = triple && (p1_raw < MIN_V);
        p1_eff    = too_short ? MIN_V : p1_raw;
    end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
#(
    parameter int P1_W   = 4,
    parameter int P2_W   = 3,
    localparam int CNT_W = (P1_W > P2_W) ? P1_W : P2_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            hsync,
    input  logic [P1_W-1:0] p1,
    input  logic [P2_W-1:0] p2,
    output logic            sp_fire,
    output logic            sample_stb,
    output logic            tx_stb
);
    seg_e             state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             tx_fire;
    logic [CNT_W-1:0] p1_x, p2_x;

    assign p1_x = CNT_W'(p1);
    assign p2_x = CNT_W'(p2);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sp_fire = 1'b0;
        tx_fire = 1'b0;
        if (hsync) begin
            state_n = ST_SYNC;
            cnt_n   = '0;
        end else if (tick) begin
            unique case (state)
                ST_SYNC: begin
                    state_n = ST_PHASE1;
                    cnt_n   = '0;
                end
                ST_PHASE1: begin
                    if (cnt >= p1_x) begin
                        state_n = ST_PHASE2;
                        cnt_n   = '0;
                        sp_fire = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_PHASE2: begin
                    if (cnt >= p2_x) begin
                        state_n = ST_SYNC;
                        cnt_n   = '0;
                        tx_fire = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_SYNC;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SYNC;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            tx_stb     <= 1'b0;
        end else begin
            sample_stb <= sp_fire;
            tx_stb     <= tx_fire;
        end
    end

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));
    a_r9_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || tx_stb) |-> $past(tick));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hsync) |=> ($stable(state) && $stable(cnt)));
    a_r2_tx_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> (state == ST_SYNC));
    a_r3_sample_in_p2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (state == ST_PHASE2 && cnt == '0));
    a_r7_hsync_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> (state == ST_SYNC && cnt == '0 && !tx_stb && !sample_stb));
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_rx,
    input  logic bus_idle,
    input  logic triple,
    input  logic sp_fire,
    output logic hsync,
    output logic sample_bit
);
    logic       bus_q;
    logic [1:0] hist;
    logic       vote;

    always_comb begin
        hsync = bus_idle && bus_q && !bus_rx;
        if (triple)
            vote = (hist[1] & hist[0]) | (hist[1] & bus_rx) | (hist[0] & bus_rx);
        else
            vote = bus_rx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q      <= 1'b1;
            hist       <= 2'b11;
            sample_bit <= 1'b1;
        end else begin
            bus_q <= bus_rx;
            if (tick)
                hist <= {hist[0], bus_rx};
            if (sp_fire)
                sample_bit <= vote;
        end
    end

    a_r9_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_fire |=> $stable(sample_bit));
    a_r8_sync_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |-> !hsync);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int P1_W   = 4,
    parameter int P2_W   = 3,
    parameter int MIN_P1 = 2,
    localparam int CFG_W = 1 + P1_W + P2_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tq_tick,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic             bus_rx,
    input  logic             bus_idle,
    output logic             sample_stb,
    output logic             sample_bit,
    output logic             tx_stb,
    output logic             cfg_err
);
    logic            triple;
    logic [P1_W-1:0] p1_eff;
    logic [P2_W-1:0] p2;
    logic            hsync;
    logic            sp_fire;

    cbt_cfg_decode #(.P1_W(P1_W), .P2_W(P2_W), .MIN_P1(MIN_P1)) u_dec (
        .cfg       (timing_cfg),
        .triple    (triple),
        .p1_eff    (p1_eff),
        .p2        (p2),
        .too_short (cfg_err)
    );

    cbt_seq #(.P1_W(P1_W), .P2_W(P2_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tq_tick),
        .hsync      (hsync),
        .p1         (p1_eff),
        .p2         (p2),
        .sp_fire    (sp_fire),
        .sample_stb (sample_stb),
        .tx_stb     (tx_stb)
    );

    cbt_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tq_tick),
        .bus_rx     (bus_rx),
        .bus_idle   (bus_idle),
        .triple     (triple),
        .sp_fire    (sp_fire),
        .hsync      (hsync),
        .sample_bit (sample_bit)
    );

    a_r6_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && cfg_err) |-> timing_cfg[CFG_W-1]);
endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_tick = 1'b0;
    logic [7:0] timing_cfg = 8'h00;
    logic       bus_rx = 1'b1;
    logic       bus_idle = 1'b0;
    logic       sample_stb, sample_bit, tx_stb, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the bit position
    int pos, s1, s2, blen;
    bit triple_m;
    bit bh0, bh1, exp_bit;

    always #2.5 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .timing_cfg(timing_cfg),
        .bus_rx(bus_rx), .bus_idle(bus_idle), .sample_stb(sample_stb),
        .sample_bit(sample_bit), .tx_stb(tx_stb), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic apply_cfg(input logic [7:0] c);
        int p1;
        @(negedge clk);
        rst_n = 1'b0;
        timing_cfg = c;
        bus_rx = 1'b1;
        bus_idle = 1'b0;
        tq_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        triple_m = c[7];
        p1 = int'(c[3:0]);
        if (triple_m && p1 < 2) p1 = 2;
        s1 = p1 + 1;
        s2 = int'(c[6:4]) + 1;
        blen = 1 + s1 + s2;
        pos = 0;
        bh0 = 1'b1;
        bh1 = 1'b1;
        exp_bit = 1'b1;
    endtask

    task automatic do_tick(input bit v, input string scen);
        bit es, et;
        es = (pos == s1);
        et = (pos == s1 + s2);
        if (es) exp_bit = triple_m ? ((bh1 & bh0) | (bh1 & v) | (bh0 & v)) : v;
        @(negedge clk);
        tq_tick = 1'b1;
        bus_rx = v;
        @(negedge clk);
        tq_tick = 1'b0;
        check({scen, " R3 sample_stb"}, int'(sample_stb), int'(es));
        check({scen, " R2 tx_stb"}, int'(tx_stb), int'(et));
        if (es) check({scen, triple_m ? " R5 bit" : " R4 bit"}, int'(sample_bit), int'(exp_bit));
        @(negedge clk);
        check({scen, " R9 strobes low"}, int'(sample_stb | tx_stb), 0);
        check({scen, " R9 bit held"}, int'(sample_bit), int'(exp_bit));
        bh1 = bh0;
        bh0 = v;
        pos = (pos + 1) % blen;
    endtask

    task automatic edge_event(input bit idle, input string scen);
        @(negedge clk);
        bus_rx = 1'b1;
        bus_idle = idle;
        @(negedge clk);
        bus_rx = 1'b0;
        @(negedge clk);
        bus_idle = 1'b0;
        check({scen, " no strobe on edge"}, int'(sample_stb | tx_stb), 0);
        if (idle) pos = 0;
    endtask

    task automatic t_reset();
        apply_cfg(8'h00);
        check("R1 reset sample_stb", int'(sample_stb), 0);
        check("R1 reset tx_stb", int'(tx_stb), 0);
        check("R1 reset cfg_err", int'(cfg_err), 0);
        check("R1 reset sample_bit", int'(sample_bit), 1);
        for (int i = 0; i < 9; i++) do_tick(1'b1, "R1 zero cfg");
    endtask

    task automatic t_single();
        apply_cfg(8'h23);
        check("R6 single no err", int'(cfg_err), 0);
        for (int i = 0; i < 32; i++) do_tick(((i % 5) == 4) ^ ((i % 3) == 0), "R4 single");
        apply_cfg(8'h01);
        check("R6 single small p1 no err", int'(cfg_err), 0);
        for (int i = 0; i < 20; i++) do_tick(i[1] ^ i[0], "R2 short bit");
    endtask

    task automatic t_triple();
        logic [15:0] pat = 16'hB4D3;
        apply_cfg(8'hA4);
        check("R6 triple ok no err", int'(cfg_err), 0);
        for (int i = 0; i < 48; i++) begin
            do_tick(pat[i % 16], "R5 triple");
        end
        apply_cfg(8'h93);
        for (int i = 0; i < 36; i++) do_tick(((i % 7) < 3), "R5 triple glitch");
    endtask

    task automatic t_clamp();
        apply_cfg(8'h90);
        check("R6 clamp err", int'(cfg_err), 1);
        for (int i = 0; i < 24; i++) do_tick(i[0] | i[2], "R6 clamp");
        apply_cfg(8'h81);
        check("R6 clamp err p1=1", int'(cfg_err), 1);
        for (int i = 0; i < 14; i++) do_tick(i[1], "R6 clamp1");
    endtask

    task automatic t_hsync();
        apply_cfg(8'h34);
        for (int i = 0; i < 5; i++) do_tick(1'b1, "R7 pre");
        edge_event(1'b1, "R7 idle edge");
        for (int i = 0; i < 22; i++) do_tick(i[0], "R7 realigned");
        apply_cfg(8'h34);
        for (int i = 0; i < 6; i++) do_tick(1'b1, "R8 pre");
        edge_event(1'b0, "R8 busy edge");
        for (int i = 0; i < 22; i++) do_tick(i[1], "R8 unchanged");
    endtask

    initial begin
        t_reset();
        t_single();
        t_triple();
        t_clamp();
        t_hsync();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule